// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates between seven interrupt sources and hands the instruction sequencer one vectored request at a time. There are four external pins, which are active low, and three internal request lines from the first timer, the second timer and the serial port, which are active high. Each external pin can be set to edge detection or level detection. Each source has its own enable and priority bit. A single global enable gates all of them.

The controller tracks which priority levels are currently in service. When the sequencer accepts a request by pulsing `take_i`, the level of that request is marked as in service. A `reti_i` pulse ends the innermost active level. A high-priority request may interrupt a low-priority handler. Nothing interrupts a high-priority handler. Within one level, ties are broken by a fixed polling order.

Source positions, from highest to lowest polling order:

| Position | Source | Vector |
|---|---|---|
| 0 | `ext_n_i[0]` | 03H |
| 1 | `periph_i[0]` | 0BH |
| 2 | `ext_n_i[1]` | 13H |
| 3 | `periph_i[1]` | 1BH |
| 4 | `periph_i[2]` | 23H |
| 5 | `ext_n_i[2]` | 33H |
| 6 | `ext_n_i[3]` | 3BH |

Bit k of `src_en_i` and bit k of `src_prio_i` refer to position k. Bit j of `edge_mode_i` selects edge mode for `ext_n_i[j]`.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `req_o` is 0 and `in_svc_o` is 2'b00.
- R2: While `req_o` is 1, `vector_o` equals the vector of the selected position, as listed in the table above.
- R3: Among eligible requests of the same priority, the lowest position is selected.
- R4: An eligible request with `src_prio_i` bit 1 is selected over every eligible request with priority bit 0, whatever their positions.
- R5: `in_svc_o[0]` marks the low level as in service and `in_svc_o[1]` marks the high level. While the high level is in service, `req_o` is 0. While only the low level is in service, only high-priority requests raise `req_o`, and `sel_hi_o` is then 1.
- R6: `take_i` while `req_o` is 1 sets the `in_svc_o` bit of the selected request's priority on the next clock. `reti_i` clears bit 1 if it is set, and otherwise clears bit 0. A preempted low level therefore becomes the active level again.
- R7: With `edge_mode_i[j]` set to 1, external pin j is sampled each clock. A high sample followed by a low sample latches a pending flag. The request stays pending after the pin returns high, and it is cleared only when that source's request is taken.
- R8: With `edge_mode_i[j]` set to 0, external pin j requests exactly while it is low. Nothing is latched.
- R9: While `global_en_i` is 0, `req_o` is 0. Edge flags that are pending are kept and are presented again once the global enable returns.
- R10: A source whose `src_en_i` bit is 0 is never selected.
- R11: `periph_i` lines are level requests owned by their peripherals. Taking such a request does not clear it, so it requests again once its level leaves service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 4 | External interrupt pins, active low |
| periph_i | input | 3 | Timer 0, timer 1 and serial request lines, active high |
| edge_mode_i | input | 4 | Edge (1) or level (0) detection per external pin |
| src_en_i | input | 7 | Per-position enable |
| src_prio_i | input | 7 | Per-position priority, 1 = high |
| global_en_i | input | 1 | Global interrupt enable |
| take_i | input | 1 | Sequencer accepts the current request |
| reti_i | input | 1 | Return from interrupt, ends the innermost level |
| req_o | output | 1 | A request is presented |
| vector_o | output | 8 | Vector address of the selected request |
| sel_hi_o | output | 1 | Selected request is high priority |
| in_svc_o | output | 2 | In-service levels: bit 0 low, bit 1 high |

## Verification
A wrong in-service state shows up on the next clock as a request that is wrongly masked, or one that wrongly leaks through, at `req_o`. `in_svc_o` also exposes this state directly after each `take_i` or `reti_i`. A lost or stuck edge flag appears as `req_o` failing to rise one cycle after a falling edge, or failing to drop after the request is taken and its level is released. Selection faults appear at once on `vector_o` whenever two or more eligible sources are raised together.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC     = 7;
  localparam int NEXT     = 4;
  localparam int NPER     = 3;
  localparam int SW       = $clog2(NSRC);
  localparam int VW       = 8;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int GAP_AT   = 5;  // vector slot skipped before this position
  localparam int EXT_POS [NEXT] = '{0, 2, 5, 6};
  localparam int PER_POS [NPER] = '{1, 3, 4};

  function automatic logic [VW-1:0] vec_of(input logic [SW-1:0] idx);
    int slot;
    slot = int'(idx) + ((int'(idx) >= GAP_AT) ? 1 : 0);
    return VW'(VEC_BASE + VEC_STEP * slot);
  endfunction
endpackage

// File: rtl/irq_edge_src.sv
module irq_edge_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, flag_q, fall;

  assign fall = prev_q & ~pin_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_n_i;
      if (!edge_mode_i)  flag_q <= 1'b0;
      else if (fall)     flag_q <= 1'b1;  // new edge wins over clear
      else if (clr_i)    flag_q <= 1'b0;
    end
  end

  assign pend_o = edge_mode_i ? flag_q : ~pin_n_i;
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_vec_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] prio_i,
  input  logic            gen_i,
  input  logic [1:0]      in_svc_i,
  output logic            req_o,
  output logic [SW-1:0]   idx_o,
  output logic            hi_o
);
  logic [NSRC-1:0] elig, hi_c, lo_c, cand;

  always_comb begin
    elig = gen_i ? (pend_i & en_i) : '0;
    hi_c = elig & prio_i;
    lo_c = elig & ~prio_i;
    if (in_svc_i[1])                cand = '0;
    else if (in_svc_i[0] || |hi_c)  cand = hi_c;
    else                            cand = lo_c;
    idx_o = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (cand[k]) idx_o = SW'(k);
    end
    req_o = |cand;
    hi_o  = req_o & prio_i[idx_o];
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       push_hi_i,
  input  logic       pop_i,
  output logic [1:0] in_svc_o
);
  logic [1:0] svc_q, popped;

  always_comb begin
    popped = svc_q;
    if (pop_i) begin
      if (svc_q[1]) popped[1] = 1'b0;
      else          popped[0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     svc_q <= 2'b00;
    else if (push_i) svc_q <= popped | (push_hi_i ? 2'b10 : 2'b01);
    else             svc_q <= popped;
  end

  assign in_svc_o = svc_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NEXT-1:0]   ext_n_i,
  input  logic [NPER-1:0]   periph_i,
  input  logic [NEXT-1:0]   edge_mode_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic [NSRC-1:0]   src_prio_i,
  input  logic              global_en_i,
  input  logic              take_i,
  input  logic              reti_i,
  output logic              req_o,
  output logic [VW-1:0]     vector_o,
  output logic              sel_hi_o,
  output logic [1:0]        in_svc_o
);
  logic [NSRC-1:0] pend;
  logic [SW-1:0]   sel_idx;
  logic            sel_req, sel_hi, taken;

  assign taken = take_i & sel_req;

  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    irq_edge_src u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_n_i    (ext_n_i[e]),
      .edge_mode_i(edge_mode_i[e]),
      .clr_i      (taken && (sel_idx == SW'(EXT_POS[e]))),
      .pend_o     (pend[EXT_POS[e]])
    );
  end

  for (genvar p = 0; p < NPER; p++) begin : g_per
    assign pend[PER_POS[p]] = periph_i[p];
  end

  irq_select u_sel (
    .pend_i  (pend),
    .en_i    (src_en_i),
    .prio_i  (src_prio_i),
    .gen_i   (global_en_i),
    .in_svc_i(in_svc_o),
    .req_o   (sel_req),
    .idx_o   (sel_idx),
    .hi_o    (sel_hi)
  );

  irq_svc_stack u_svc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (taken),
    .push_hi_i(sel_hi),
    .pop_i    (reti_i),
    .in_svc_o (in_svc_o)
  );

  assign req_o    = sel_req;
  assign sel_hi_o = sel_hi;
  assign vector_o = sel_req ? vec_of(sel_idx) : '0;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_en_i,
  input logic            global_en_i,
  input logic            take_i,
  input logic            reti_i,
  input logic            req_o,
  input logic [VW-1:0]   vector_o,
  input logic            sel_hi_o,
  input logic [1:0]      in_svc_o
);
  // R5
  hi_svc_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o[1] |-> !req_o);
  // R5
  lo_svc_hi_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && in_svc_o[0]) |-> sel_hi_o);
  // R9
  gen_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !global_en_i |-> !req_o);
  // R10
  no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_i == '0) |-> !req_o);
  // R2
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vector_o[2:0] == 3'b011));
  // R6
  take_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && req_o && !reti_i && in_svc_o == 2'b00)
      |=> (in_svc_o == ($past(sel_hi_o) ? 2'b10 : 2'b01)));
  // R6
  reti_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_i && in_svc_o == 2'b11) |=> (in_svc_o == 2'b01));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (.*);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ext_n_i = 4'hF;
  logic [2:0] periph_i = '0;
  logic [3:0] edge_mode_i = '0;
  logic [6:0] src_en_i = '0;
  logic [6:0] src_prio_i = '0;
  logic       global_en_i = 1'b0;
  logic       take_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       req_o;
  logic [7:0] vector_o;
  logic       sel_hi_o;
  logic [1:0] in_svc_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [7:0] VEC [7] = '{8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h33, 8'h3B};

  always #10 clk_i = ~clk_i;

  irq_vec_ctrl u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // position -> pin (active low for external, high for peripheral)
  task automatic set_src(input int k, input bit on);
    case (k)
      0: ext_n_i[0] = ~on;
      1: periph_i[0] = on;
      2: ext_n_i[1] = ~on;
      3: periph_i[1] = on;
      4: periph_i[2] = on;
      5: ext_n_i[2] = ~on;
      default: ext_n_i[3] = ~on;
    endcase
  endtask

  task automatic clear_all();
    ext_n_i = 4'hF; periph_i = '0;
  endtask

  task automatic pulse_take();
    @(negedge clk_i) take_i = 1'b1;
    @(negedge clk_i) take_i = 1'b0;
    #1;
  endtask

  task automatic pulse_reti();
    @(negedge clk_i) reti_i = 1'b1;
    @(negedge clk_i) reti_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk_i); #1;
    check("R1 req", req_o, 0);
    check("R1 in_svc", in_svc_o, 0);
  endtask

  task automatic t_vectors();
    global_en_i = 1; src_en_i = '1; src_prio_i = '0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i) set_src(k, 1); #1;
      check("R2 req", req_o, 1);
      check("R2 vector", vector_o, VEC[k]);
      set_src(k, 0);
    end
  endtask

  task automatic t_poll();
    @(negedge clk_i);
    for (int k = 0; k < 7; k++) set_src(k, 1);
    #1 check("R3 all", vector_o, 8'h03);
    set_src(0, 0); #1 check("R3 drop0", vector_o, 8'h0B);
    clear_all(); set_src(4, 1); set_src(6, 1);
    #1 check("R3 4v6", vector_o, 8'h23);
    clear_all();
  endtask

  task automatic t_prio();
    @(negedge clk_i) src_prio_i = 7'b1000000;
    set_src(0, 1); set_src(6, 1);
    #1 check("R4 vector", vector_o, 8'h3B);
    check("R4 hi", sel_hi_o, 1);
    clear_all(); src_prio_i = '0;
  endtask

  task automatic t_preempt();
    @(negedge clk_i) set_src(4, 1);
    pulse_take();
    check("R6 push lo", in_svc_o, 2'b01);
    check("R5 lo blocked", req_o, 0);
    src_prio_i = 7'b1000000; set_src(6, 1);
    #1 check("R5 hi preempts", vector_o, 8'h3B);
    pulse_take();
    check("R6 push hi", in_svc_o, 2'b11);
    check("R5 hi blocks", req_o, 0);
    pulse_reti();
    check("R6 pop hi", in_svc_o, 2'b01);
    check("R5 hi again", vector_o, 8'h3B);
    set_src(6, 0); #1;
    check("R5 lo still blocked", req_o, 0);
    pulse_reti();
    check("R6 pop lo", in_svc_o, 2'b00);
    check("R11 periph again", vector_o, 8'h23);
    clear_all(); src_prio_i = '0;
  endtask

  task automatic t_edge();
    @(negedge clk_i) edge_mode_i = 4'b1000;
    set_src(6, 1); #1;
    check("R7 not yet", req_o, 0);
    @(negedge clk_i) #1;
    check("R7 latched", vector_o, 8'h3B);
    set_src(6, 0);
    @(negedge clk_i) #1;
    check("R7 held", req_o, 1);
    pulse_take();
    pulse_reti();
    check("R7 cleared", req_o, 0);
    edge_mode_i = '0;
  endtask

  task automatic t_level();
    @(negedge clk_i) set_src(2, 1); #1;
    check("R8 follows", vector_o, 8'h13);
    set_src(2, 0); #1;
    check("R8 no latch", req_o, 0);
  endtask

  task automatic t_gen();
    @(negedge clk_i) edge_mode_i = 4'b0001; global_en_i = 0;
    set_src(0, 1);
    @(negedge clk_i) set_src(0, 0);
    @(negedge clk_i) #1;
    check("R9 masked", req_o, 0);
    global_en_i = 1; #1;
    check("R9 kept", vector_o, 8'h03);
    pulse_take();
    pulse_reti();
    check("R9 cleared", req_o, 0);
    edge_mode_i = '0;
  endtask

  task automatic t_en();
    @(negedge clk_i) src_en_i = 7'b0000010;
    set_src(0, 1); set_src(1, 1); #1;
    check("R10 skip0", vector_o, 8'h0B);
    set_src(1, 0); #1;
    check("R10 none", req_o, 0);
    clear_all(); src_en_i = '1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_vectors();
    t_poll();
    t_prio();
    t_preempt();
    t_edge();
    t_level();
    t_gen();
    t_en();
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule